// File: doc/BRIEF.md
# Signed Dual-Output Motor PWM Generator

This block turns a signed duty command into a drive waveform for one motor channel. It runs from a 40 MHz clock and has a fixed period of 2047 clocks, which gives about 19.5 kHz. The size of the command sets the on-time. Its sign is presented in one of two styles.

In the split style, each sign has its own pulse pin. In the magnitude-plus-direction style, one pin carries the pulse train and the other holds a direction level. A second modulation option spreads the same number of on-cycles evenly across the period instead of grouping them together.

Each pin can be flipped by a shared general-purpose output bit. A status LED output shows the XOR of the two pins. A single write strobe stages a new command, style, modulation choice and output bits. All of these become active together at the next period boundary.

Top module: `spwm_drive`

## Requirements
- R1: `wr_cmd` is 12-bit two's complement. The magnitude m is |command|, and -2048 is clamped to a magnitude of 2047. Each 2047-cycle window has exactly m on-cycles: m = 0 is never on, and m = 2047 is always on.
- R2: The period is 2047 clocks. In fixed-period mode (`wr_pdm` = 0), the on-cycles form one contiguous run per period, so a command with 0 < m < 2047 gives exactly one rising edge per 2047-cycle window.
- R3: When `wr_dir_style` = 1 (magnitude-plus-direction), `pin_a` carries the on-cycles of m. `pin_b` is held high when the command is negative and low when it is zero or positive (before the R5 XOR).
- R4: When `wr_dir_style` = 0 (split), `pin_a` carries the on-cycles for positive commands and `pin_b` for negative commands. The pin for the other sign stays low (before the R5 XOR).
- R5: `pin_a` is XORed with `wr_gpo[0]` and `pin_b` with `wr_gpo[1]`, so a set bit inverts that pin.
- R6: When `wr_pdm` = 1, a 2047-modulus accumulator spreads the m on-cycles across the window. For m = 1023, a 2047-cycle window shows at least 500 rising edges on the pulse pin.
- R7: `led` equals `pin_a` XOR `pin_b` in every cycle.
- R8: A write strobe captures the command, style, modulation bit and gpo bits into a staging register. All of them take effect together at the start of the next period. A period already under way finishes with its old settings, so no runt pulse appears.
- R9: After reset, the active command is 0, both mode bits are 0 and the gpo bits are 0. As a result `pin_a`, `pin_b` and `led` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the staging register |
| wr_cmd | input | 12 | Signed duty command |
| wr_dir_style | input | 1 | 1 = magnitude-plus-direction, 0 = split pulses |
| wr_pdm | input | 1 | 1 = spread (accumulator) modulation |
| wr_gpo | input | 2 | Per-pin XOR bits: [0] for pin_a, [1] for pin_b |
| pin_a | output | 1 | Positive pulse pin, or magnitude pulse pin |
| pin_b | output | 1 | Negative pulse pin, or direction pin |
| led | output | 1 | XOR of the two pins |

## Verification
Commands of both signs are applied in each output style. This separates the styles by where the pulse lands and what the second pin holds.

Zero, full positive scale and the clamped most-negative value test the ends of the magnitude range. The same mid-range magnitude is run in both modulation modes. Equal on-time with very different rising-edge counts shows that the spread mode is working rather than just being a renamed fixed-period mode.

A command rewritten partway through a period, with the bench aligned to the period, shows whether the old on-time is completed before the new one appears. Setting the gpo bits over a running waveform checks the pin inversion.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

    typedef enum logic {
        STYLE_SPLIT  = 1'b0,
        STYLE_MAGDIR = 1'b1
    } style_e;

    typedef enum logic {
        MOD_FIXED  = 1'b0,
        MOD_SPREAD = 1'b1
    } modsel_e;

    typedef struct packed {
        logic a;
        logic b;
    } pin_pair_t;

endpackage

// File: rtl/spwm_stage.sv
module spwm_stage
    import spwm_pkg::*;
#(
    parameter int CMD_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_cmd,
    input  style_e           wr_style,
    input  modsel_e          wr_mod,
    input  logic [1:0]       wr_gpo,
    input  logic             wrap,
    output logic [CMD_W-1:0] act_cmd,
    output style_e           act_style,
    output modsel_e          act_mod,
    output logic [1:0]       act_gpo
);

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        style_e           style;
        modsel_e          modsel;
        logic [1:0]       gpo;
    } cfg_t;

    typedef struct packed {
        cfg_t stage;
        cfg_t active;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.stage.cmd    = wr_cmd;
            st_d.stage.style  = wr_style;
            st_d.stage.modsel = wr_mod;
            st_d.stage.gpo    = wr_gpo;
        end
        if (wrap) begin
            st_d.active = st_q.stage;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_cmd   = st_q.active.cmd;
    assign act_style = st_q.active.style;
    assign act_mod   = st_q.active.modsel;
    assign act_gpo   = st_q.active.gpo;

    // The active settings move only at a period boundary.
    assert_apply_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.active) |-> $past(wrap));

endmodule

// File: rtl/spwm_mod.sv
module spwm_mod
    import spwm_pkg::*;
#(
    parameter int CMD_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] cmd,
    input  modsel_e          modsel,
    output logic             wrap,
    output logic             on,
    output logic             neg
);

    localparam int CNT_W  = CMD_W - 1;
    localparam int ACC_W  = CMD_W + 1;
    localparam int PERIOD = (1 << (CMD_W - 1)) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CMD_W-1:0] acc;
    } st_t;

    st_t st_d, st_q;

    logic [CMD_W-1:0] abs_v;
    logic [CMD_W-1:0] mag;
    logic [ACC_W-1:0] sum;
    logic             spread_on;

    always_comb begin
        neg   = cmd[CMD_W-1];
        abs_v = neg ? (~cmd + 1'b1) : cmd;
        mag   = (abs_v > CMD_W'(PERIOD)) ? CMD_W'(PERIOD) : abs_v;

        sum       = {1'b0, st_q.acc} + {1'b0, mag};
        spread_on = (sum >= ACC_W'(PERIOD));

        wrap = (st_q.cnt == CNT_W'(PERIOD - 1));

        st_d     = st_q;
        st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
        if (modsel == MOD_SPREAD) begin
            st_d.acc = spread_on ? CMD_W'(sum - ACC_W'(PERIOD)) : CMD_W'(sum);
        end else begin
            st_d.acc = '0;
        end

        if (modsel == MOD_SPREAD) begin
            on = spread_on;
        end else begin
            on = ({1'b0, st_q.cnt} < mag);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(PERIOD));

    assert_mag_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mag <= CMD_W'(PERIOD));

    assert_acc_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < CMD_W'(PERIOD));

endmodule

// File: rtl/spwm_outmux.sv
module spwm_outmux
    import spwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       on,
    input  logic       neg,
    input  style_e     style,
    input  logic [1:0] gpo,
    output logic       pin_a,
    output logic       pin_b
);

    pin_pair_t raw;
    pin_pair_t pins_d, pins_q;

    always_comb begin
        if (style == STYLE_MAGDIR) begin
            raw.a = on;
            raw.b = neg;
        end else begin
            raw.a = on & ~neg;
            raw.b = on & neg;
        end
        pins_d.a = raw.a ^ gpo[0];
        pins_d.b = raw.b ^ gpo[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= '0;
        end else begin
            pins_q <= pins_d;
        end
    end

    assign pin_a = pins_q.a;
    assign pin_b = pins_q.b;

    // Split style never drives both pulse pins at once.
    assert_split_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (style == STYLE_SPLIT && gpo == 2'b00) |=> !(pin_a && pin_b));

endmodule

// File: rtl/spwm_drive.sv
module spwm_drive
    import spwm_pkg::*;
#(
    parameter int CMD_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_cmd,
    input  logic             wr_dir_style,
    input  logic             wr_pdm,
    input  logic [1:0]       wr_gpo,
    output logic             pin_a,
    output logic             pin_b,
    output logic             led
);

    logic [CMD_W-1:0] act_cmd;
    style_e           act_style;
    modsel_e          act_mod;
    logic [1:0]       act_gpo;
    logic             wrap;
    logic             on;
    logic             neg;

    spwm_stage #(.CMD_W(CMD_W)) i_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_cmd    (wr_cmd),
        .wr_style  (style_e'(wr_dir_style)),
        .wr_mod    (modsel_e'(wr_pdm)),
        .wr_gpo    (wr_gpo),
        .wrap      (wrap),
        .act_cmd   (act_cmd),
        .act_style (act_style),
        .act_mod   (act_mod),
        .act_gpo   (act_gpo)
    );

    spwm_mod #(.CMD_W(CMD_W)) i_mod (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (act_cmd),
        .modsel (act_mod),
        .wrap   (wrap),
        .on     (on),
        .neg    (neg)
    );

    spwm_outmux i_outmux (
        .clk   (clk),
        .rst_n (rst_n),
        .on    (on),
        .neg   (neg),
        .style (act_style),
        .gpo   (act_gpo),
        .pin_a (pin_a),
        .pin_b (pin_b)
    );

    assign led = pin_a ^ pin_b;

    assert_reset_quiet_R9: assert property (@(posedge clk)
        $past(!rst_n) && !rst_n |=> !pin_a && !pin_b);

endmodule

// File: tb/test_spwm_drive.sv
module test_spwm_drive;

    localparam int PER = 2047;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_cmd = '0;
    logic        wr_dir_style = 1'b0;
    logic        wr_pdm = 1'b0;
    logic [1:0]  wr_gpo = '0;
    logic        pin_a, pin_b, led;

    int n_chk = 0;
    int n_bad = 0;
    int hi_a, hi_b, rise_a, led_bad;

    always #5 clk = ~clk;

    spwm_drive i_spwm_drive (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .wr_dir_style(wr_dir_style), .wr_pdm(wr_pdm), .wr_gpo(wr_gpo),
        .pin_a(pin_a), .pin_b(pin_b), .led(led)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input int act, input int lim);
        n_chk++;
        if (act < lim) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected >= %0d", req, act, lim);
        end
    endtask

    task automatic write(input int cmd, input bit dir, input bit pdm, input bit [1:0] gpo);
        @(negedge clk);
        wr_en = 1'b1; wr_cmd = 12'(cmd); wr_dir_style = dir; wr_pdm = pdm; wr_gpo = gpo;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Measure one 2047-cycle window at falling edges.
    task automatic window();
        logic prev;
        hi_a = 0; hi_b = 0; rise_a = 0; led_bad = 0;
        prev = pin_a;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            hi_a += int'(pin_a);
            hi_b += int'(pin_b);
            if (pin_a && !prev) rise_a++;
            if (led !== (pin_a ^ pin_b)) led_bad++;
            prev = pin_a;
        end
    endtask

    task automatic apply_and_measure(input int cmd, input bit dir, input bit pdm, input bit [1:0] gpo);
        write(cmd, dir, pdm, gpo);
        repeat (2 * PER + 4) @(negedge clk);
        window();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R9 pin_a", int'(pin_a), 0);
        check("R9 pin_b", int'(pin_b), 0);
        check("R9 led", int'(led), 0);
    endtask

    task automatic t_magdir();
        apply_and_measure(600, 1'b1, 1'b0, 2'b00);
        check("R3 pos pulse count", hi_a, 600);
        check("R3 pos dir low", hi_b, 0);
        check("R2 one rise per period", rise_a, 1);
        check("R7 led", led_bad, 0);
        apply_and_measure(-600, 1'b1, 1'b0, 2'b00);
        check("R3 neg pulse count", hi_a, 600);
        check("R3 neg dir high", hi_b, PER);
        check("R7 led neg", led_bad, 0);
    endtask

    task automatic t_split();
        apply_and_measure(700, 1'b0, 1'b0, 2'b00);
        check("R4 pos on pin_a", hi_a, 700);
        check("R4 pos pin_b idle", hi_b, 0);
        apply_and_measure(-700, 1'b0, 1'b0, 2'b00);
        check("R4 neg pin_a idle", hi_a, 0);
        check("R4 neg on pin_b", hi_b, 700);
    endtask

    task automatic t_limits();
        apply_and_measure(2047, 1'b0, 1'b0, 2'b00);
        check("R1 full scale", hi_a, PER);
        apply_and_measure(0, 1'b0, 1'b0, 2'b00);
        check("R1 zero a", hi_a, 0);
        check("R1 zero b", hi_b, 0);
        apply_and_measure(-2048, 1'b0, 1'b0, 2'b00);
        check("R1 clamp b", hi_b, PER);
        check("R1 clamp a", hi_a, 0);
    endtask

    task automatic t_gpo();
        apply_and_measure(300, 1'b0, 1'b0, 2'b11);
        check("R5 inverted a", hi_a, PER - 300);
        check("R5 inverted b", hi_b, PER);
        check("R7 led with gpo", led_bad, 0);
    endtask

    task automatic t_spread();
        apply_and_measure(1023, 1'b1, 1'b1, 2'b00);
        check("R6 spread count", hi_a, 1023);
        check_ge("R6 spread rises", rise_a, 500);
        apply_and_measure(1023, 1'b1, 1'b0, 2'b00);
        check("R2 fixed rises", rise_a, 1);
    endtask

    task automatic t_no_runt();
        logic prev;
        int   cnt_old, cnt_new;
        apply_and_measure(1000, 1'b0, 1'b0, 2'b00);
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (pin_a && !prev) break;
            prev = pin_a;
        end
        cnt_old = 1;
        for (int i = 1; i < PER; i++) begin
            @(negedge clk);
            if (i == 100) begin
                wr_en = 1'b1; wr_cmd = 12'd50; wr_dir_style = 1'b0; wr_pdm = 1'b0; wr_gpo = 2'b00;
            end else begin
                wr_en = 1'b0;
            end
            cnt_old += int'(pin_a);
        end
        cnt_new = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            cnt_new += int'(pin_a);
        end
        check("R8 period finishes old", cnt_old, 1000);
        check("R8 next period new", cnt_new, 50);
    endtask

    initial begin
        #(10 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_magdir();
        t_split();
        t_limits();
        t_gpo();
        t_spread();
        t_no_runt();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule